// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is the master side of a two-wire serial bus. A host hands it one command at a time over a valid/ready handshake. The commands are START, repeated START, write byte, read byte with acknowledge, read byte without acknowledge, and STOP. The block turns each command into the matching SCL/SDA waveform. Both lines are open-drain: the block outputs only a pull-low enable per line and never drives either line high. SDA is read back through a synchronizer. A 16-bit divider sets the length of one quarter of an SCL period.

A complete transaction with a 7-bit target address is built from these commands. The host sends START, then writes the address byte with the direction bit in bit 0 (0 = master sends, 1 = master receives), then moves data bytes, then sends STOP. A repeated START followed by a new address byte changes direction or target without releasing the bus. When the master reads, it acknowledges each byte except the last, which it leaves unacknowledged before STOP or a repeated START. Each command ends with a one-cycle done pulse. The pulse carries the byte sampled from SDA and the level sampled during the ninth clock. SCL stretching by targets and multi-master arbitration are not handled. The divider value must be at least 1.

Top module: `i2cm_master`

## Requirements
- R1: During and right after reset, both pull enables are off (lines released), busy is 0, cmd_ready is 1 and done is 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. From the next cycle, busy is 1 and cmd_ready is 0 until the command completes. On completion, busy falls and done is 1 for exactly one cycle.
- R3: Each phase lasts clk_div+1 cycles. clk_div is captured when the command is accepted. START (op 0), repeated START (op 1) and STOP (op 5) take 4 phases. Write (op 2), read-with-ACK (op 3) and read-with-NACK (op 4) take 36 phases. Done is high exactly phases*(clk_div+1) cycles after the accepting edge.
- R4: START and repeated START first release SDA while SCL is low. They then release SCL, then pull SDA low while SCL is high, and they end with both lines pulled low.
- R5: STOP pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is high. It ends with both lines released.
- R6: A write sends the byte most significant bit first. SDA changes only while SCL is low. SDA is released for the ninth clock, and the level sampled in that clock is returned on done_ack (0 = acknowledged). done_data returns the eight sampled data bits.
- R7: A read releases SDA for eight clocks and returns on done_data the bits sampled at the middle of each SCL-high time, first bit in bit 7.
- R8: On the ninth clock, read-with-ACK pulls SDA low and read-with-NACK leaves SDA released. done_ack reports the level sampled in that clock.
- R9: A repeated START issued after a byte, with SCL low and SDA at any level, produces a START condition the target recognises. No STOP is produced.
- R10: If the address byte is not acknowledged, done_ack is 1. A following STOP completes and leaves both lines released.
- R11: For START, repeated START and STOP, done_data is 0 and done_ack is 0.
- R12: Op codes 6 and 7 are accepted and complete after one phase. Neither line changes, and done_data and done_ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 16 | Phase length minus one, in clock cycles |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 8 | Byte to write (address or data) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 8 | Byte sampled during the command |
| done_ack | output | 1 | SDA level sampled on the ninth clock |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
Every result has a fixed due cycle. busy and cmd_ready change one cycle after the accepting edge, and done, done_data and done_ack are due exactly phases*(clk_div+1) cycles after that edge. A behavioural model in the bench counts down that delay for each accepted command. Its busy, ready and done are compared with the block's outputs on every falling clock edge, which is away from the edge where the block updates. Byte results and line levels are read only in the cycle done is high. A target model on the open-drain bus judges START, STOP, address match and data bits on its own, so waveform order is checked independently of the block's phase counting.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [2:0] OP_START   = 3'd0;
  localparam logic [2:0] OP_RESTART = 3'd1;
  localparam logic [2:0] OP_WRITE   = 3'd2;
  localparam logic [2:0] OP_RD_ACK  = 3'd3;
  localparam logic [2:0] OP_RD_NACK = 3'd4;
  localparam logic [2:0] OP_STOP    = 3'd5;

  localparam int BYTE_BITS   = 8;
  localparam int PH_PER_BIT  = 4;
  localparam int BYTE_PHASES = (BYTE_BITS + 1) * PH_PER_BIT;
  localparam int PH_W        = $clog2(BYTE_PHASES);

  typedef logic [PH_W-1:0] phase_t;

  // 1 = pull the line low, 0 = release it
  typedef struct packed {
    logic scl;
    logic sda;
  } pull_t;

  function automatic logic is_cond(input logic [2:0] op);
    return (op == OP_START) || (op == OP_RESTART) || (op == OP_STOP);
  endfunction

  function automatic logic is_byte(input logic [2:0] op);
    return (op == OP_WRITE) || (op == OP_RD_ACK) || (op == OP_RD_NACK);
  endfunction

  function automatic phase_t last_phase(input logic [2:0] op);
    if (is_byte(op))      return phase_t'(BYTE_PHASES - 1);
    else if (is_cond(op)) return phase_t'(PH_PER_BIT - 1);
    else                  return '0;
  endfunction

  // Line pattern for phase ph of a moving command
  function automatic pull_t line_pattern(input logic [2:0] op, input phase_t ph,
                                         input logic [7:0] data);
    pull_t      p;
    logic [1:0] q;
    logic [3:0] bi;
    logic       bitval;
    q  = ph[1:0];
    bi = ph[5:2];
    p  = '0;
    if (op == OP_STOP) begin
      p.scl = (q == 2'd0);
      p.sda = (q == 2'd0) || (q == 2'd1);
    end else if (is_cond(op)) begin
      p.scl = (q == 2'd0) || (q == 2'd3);
      p.sda = (q == 2'd2) || (q == 2'd3);
    end else begin
      p.scl = (q == 2'd0) || (q == 2'd3);
      if (bi < 4'd8)
        bitval = (op == OP_WRITE) ? data[~bi[2:0]] : 1'b1;
      else
        bitval = (op == OP_RD_ACK) ? 1'b0 : 1'b1;
      p.sda = ~bitval;
    end
    return p;
  endfunction
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;

  assign tick = run && (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      div_q <= div_in;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= div_q));
  p_div_held_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> (div_q == $past(div_q)));
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       sda_s,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       cmd_ready,
  output logic       busy,
  output logic       accept,
  output logic       done,
  output logic [7:0] done_data,
  output logic       done_ack,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic [2:0] op_q;
  logic [7:0] data_q;
  logic [7:0] rx_q;
  logic       ack_q;
  phase_t     ph_q;
  pull_t      nxt;
  logic       sample_now;

  assign accept     = cmd_valid && cmd_ready;
  assign sample_now = busy && tick && (ph_q[1:0] == 2'd1);

  always_comb begin
    if (accept) nxt = line_pattern(cmd_op, '0, cmd_data);
    else        nxt = line_pattern(op_q, ph_q + 1'b1, data_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ready <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      done_ack  <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      op_q      <= '0;
      data_q    <= '0;
      rx_q      <= '0;
      ack_q     <= 1'b0;
      ph_q      <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cmd_ready <= 1'b0;
        busy      <= 1'b1;
        op_q      <= cmd_op;
        data_q    <= cmd_data;
        rx_q      <= '0;
        ack_q     <= 1'b0;
        ph_q      <= '0;
        if (is_cond(cmd_op) || is_byte(cmd_op)) begin
          scl_oe <= nxt.scl;
          sda_oe <= nxt.sda;
        end
      end else if (busy && tick) begin
        if (sample_now) begin
          if (ph_q[5:2] < 4'd8) rx_q <= {rx_q[6:0], sda_s};
          else                  ack_q <= sda_s;
        end
        if (ph_q == last_phase(op_q)) begin
          busy      <= 1'b0;
          cmd_ready <= 1'b1;
          done      <= 1'b1;
          done_data <= is_byte(op_q) ? rx_q : 8'h00;
          done_ack  <= is_byte(op_q) ? ack_q : 1'b0;
        end else begin
          ph_q <= ph_q + 1'b1;
          if (is_cond(op_q) || is_byte(op_q)) begin
            scl_oe <= nxt.scl;
            sda_oe <= nxt.sda;
          end
        end
      end
    end
  end

  p_ready_busy_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_ready == !busy);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !cmd_ready));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_end_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_sda_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> is_cond(op_q));
  p_start_end_r4: assert property (@(posedge clk) disable iff (rst)
    (done && (op_q == OP_START || op_q == OP_RESTART)) |-> (scl_oe && sda_oe));
  p_stop_end_r5: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_STOP) |-> (!scl_oe && !sda_oe));
  p_cond_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (done && is_cond(op_q)) |-> (done_data == 8'h00 && !done_ack));
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master #(
  parameter int DIV_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  output logic             busy,
  output logic             done,
  output logic [7:0]       done_data,
  output logic             done_ack,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  logic tick;
  logic accept;
  logic sda_s;

  i2cm_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (sda_i),
    .dout(sda_s)
  );

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .run   (busy),
    .div_in(clk_div),
    .tick  (tick)
  );

  i2cm_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sda_s    (sda_s),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_data (cmd_data),
    .cmd_ready(cmd_ready),
    .busy     (busy),
    .accept   (accept),
    .done     (done),
    .done_data(done_data),
    .done_ack (done_ack),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );
endmodule

// File: tb/i2cm_master_tb_top.sv
`timescale 1ns/1ps
module i2cm_master_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] clk_div = 16'd3;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  cmd_data = 8'h00;
  logic        cmd_ready, busy, done, done_ack, scl_oe, sda_oe;
  logic [7:0]  done_data;
  logic        tgt_pull = 1'b0;
  logic        scl_bus, sda_bus;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || tgt_pull);

  i2cm_master dut_i (
    .clk(clk), .rst(rst), .clk_div(clk_div), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy),
    .done(done), .done_data(done_data), .done_ack(done_ack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_bus)
  );

  // ---------------- timing reference model ----------------
  int         m_rem = 0;
  logic       m_busy = 1'b0;
  logic       m_done = 1'b0;
  logic [2:0] m_op = 3'd7;

  function automatic int phases_of(input logic [2:0] op);
    if (op == 3'd0 || op == 3'd1 || op == 3'd5) return 4;
    if (op == 3'd2 || op == 3'd3 || op == 3'd4) return 36;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_rem <= 0;
    end else if (m_busy) begin
      m_done <= (m_rem == 1);
      if (m_rem == 1) m_busy <= 1'b0;
      m_rem <= m_rem - 1;
    end else begin
      m_done <= 1'b0;
      if (cmd_valid) begin
        m_busy <= 1'b1;
        m_rem  <= phases_of(cmd_op) * (int'(clk_div) + 1);
        m_op   <= cmd_op;
      end
    end
  end

  int   clk_checks = 0;
  int   clk_fails  = 0;
  logic p_scl = 1'b1;
  logic p_sda = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      clk_checks++;
      if (busy !== m_busy || cmd_ready !== !m_busy || done !== m_done) begin
        clk_fails++;
        $display("FAIL R2/R3 cycle timing: busy=%0b ready=%0b done=%0b expected busy=%0b ready=%0b done=%0b",
                 busy, cmd_ready, done, m_busy, !m_busy, m_done);
      end
      if (p_scl && scl_bus && (sda_bus !== p_sda) &&
          !(m_op == 3'd0 || m_op == 3'd1 || m_op == 3'd5)) begin
        clk_fails++;
        $display("FAIL R6 SDA moved with SCL high: sda=%0b expected %0b", sda_bus, p_sda);
      end
    end
    p_scl = scl_bus;
    p_sda = sda_bus;
  end

  // ---------------- target model on the bus ----------------
  localparam logic [6:0] TADDR = 7'h5A;
  int         t_state = 0;   // 0 idle, 1 address, 2 write, 3 read, 4 ignore
  int         t_bit = 0;
  int         t_starts = 0;
  int         t_stops = 0;
  int         t_rd_idx = 0;
  logic       t_fresh = 1'b0;
  logic       t_dir = 1'b0;
  logic       t_mack = 1'b1;
  logic [7:0] t_sh = 8'h00;
  logic [7:0] t_tx = 8'h00;
  logic [7:0] t_wr = 8'h00;
  logic       b_scl = 1'b1;
  logic       b_sda = 1'b1;

  function automatic logic [7:0] rd_byte(input int idx);
    return (idx == 0) ? 8'h96 : 8'h3C;
  endfunction

  always @(scl_bus or sda_bus) begin
    if (scl_bus === 1'b1 && b_scl && b_sda && sda_bus === 1'b0) begin
      t_state = 1; t_fresh = 1'b1; t_sh = 8'h00; tgt_pull = 1'b0; t_starts++;
    end else if (scl_bus === 1'b1 && b_scl && !b_sda && sda_bus === 1'b1) begin
      t_state = 0; tgt_pull = 1'b0; t_stops++;
    end else if (scl_bus === 1'b1 && !b_scl) begin
      if (t_state != 0) begin
        if (t_bit < 8) t_sh = {t_sh[6:0], sda_bus};
        else           t_mack = sda_bus;
      end
    end else if (scl_bus === 1'b0 && b_scl && t_state != 0) begin
      if (t_fresh) begin
        t_fresh = 1'b0; t_bit = 0; tgt_pull = 1'b0;
      end else begin
        t_bit++;
        if (t_bit < 8) begin
          tgt_pull = (t_state == 3) ? ~t_tx[7 - t_bit] : 1'b0;
        end else if (t_bit == 8) begin
          if (t_state == 1) begin
            if (t_sh[7:1] == TADDR) begin tgt_pull = 1'b1; t_dir = t_sh[0]; end
            else begin tgt_pull = 1'b0; t_state = 4; end
          end else if (t_state == 2) begin
            t_wr = t_sh; tgt_pull = 1'b1;
          end else tgt_pull = 1'b0;
        end else begin
          t_bit = 0;
          if (t_state == 1) begin
            if (t_dir) begin
              t_state = 3; t_rd_idx = 0; t_tx = rd_byte(0); tgt_pull = ~t_tx[7];
            end else begin t_state = 2; tgt_pull = 1'b0; end
          end else if (t_state == 3) begin
            if (!t_mack) begin
              t_rd_idx++; t_tx = rd_byte(t_rd_idx); tgt_pull = ~t_tx[7];
            end else begin t_state = 4; tgt_pull = 1'b0; end
          end else tgt_pull = 1'b0;
        end
      end
    end
    b_scl = (scl_bus === 1'b1);
    b_sda = (sda_bus === 1'b1);
  end

  // ---------------- stimulus and checks ----------------
  int tests = 0;
  int fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] data,
                     output logic [7:0] d, output logic a);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    d = done_data;
    a = done_ack;
  endtask

  initial begin
    logic [7:0] d;
    logic       a;
    logic       s0, s1;
    fork
      begin
        repeat (5) @(negedge clk);
        chk("R1 scl_oe in reset", scl_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 done", done, 0);

        // write then repeated start into read
        run(3'd0, 8'h00, d, a);
        chk("R4 start lines", {scl_oe, sda_oe}, 2'b11);
        chk("R4 start seen", t_starts, 1);
        chk("R11 start data", d, 0);
        chk("R11 start ack", a, 0);
        run(3'd2, 8'hB4, d, a);
        chk("R6 address ack", a, 0);
        chk("R6 readback", d, 8'hB4);
        run(3'd2, 8'hC3, d, a);
        chk("R6 data ack", a, 0);
        chk("R6 byte at target", t_wr, 8'hC3);
        run(3'd1, 8'h00, d, a);
        chk("R9 restart seen", t_starts, 2);
        chk("R9 no stop", t_stops, 0);
        chk("R9 lines", {scl_oe, sda_oe}, 2'b11);
        run(3'd2, 8'hB5, d, a);
        chk("R9 read address ack", a, 0);
        run(3'd3, 8'h00, d, a);
        chk("R7 first read byte", d, 8'h96);
        chk("R8 ack level", a, 0);
        chk("R8 target saw ack", t_mack, 0);
        run(3'd4, 8'h00, d, a);
        chk("R7 last read byte", d, 8'h3C);
        chk("R8 nack level", a, 1);
        run(3'd5, 8'h00, d, a);
        chk("R5 stop lines", {scl_oe, sda_oe}, 2'b00);
        chk("R5 stop seen", t_stops, 1);
        chk("R11 stop ack", a, 0);

        // unknown op and address refused
        run(3'd0, 8'h00, d, a);
        s0 = scl_oe; s1 = sda_oe;
        run(3'd6, 8'hFF, d, a);
        chk("R12 lines held", {scl_oe, sda_oe}, {s0, s1});
        chk("R12 data", d, 0);
        chk("R12 ack", a, 0);
        run(3'd2, 8'h20, d, a);
        chk("R10 address nack", a, 1);
        run(3'd5, 8'h00, d, a);
        chk("R10 abort lines", {scl_oe, sda_oe}, 2'b00);
        chk("R10 abort seen", t_stops, 2);
        run(3'd7, 8'h00, d, a);
        chk("R12 op 7 lines", {scl_oe, sda_oe}, 2'b00);

        // slower divider
        clk_div = 16'd6;
        run(3'd0, 8'h00, d, a);
        run(3'd2, 8'hB4, d, a);
        chk("R3 slow address ack", a, 0);
        run(3'd2, 8'h5A, d, a);
        chk("R6 slow byte at target", t_wr, 8'h5A);
        run(3'd5, 8'h00, d, a);
        chk("R5 slow stop", {scl_oe, sda_oe}, 2'b00);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests + clk_checks, fails + clk_fails);
    $finish;
  end
endmodule